// File: doc/BRIEF.md
# Encoded ALU with Shifter and Strobed Flags

This combinational datapath unit sits behind the register file of a small 8-bit accumulator-style processor. Each cycle it takes two register operands and, when asked, an 8-bit immediate in place of the second operand. It applies a logic or arithmetic function, then an optional shift or rotate, and drives one result back to the write port of the register file. The function and the shift are picked by two separate 3-bit codes. The code values are fixed because the instruction decoder produces them.

The unit holds two flags, zero and carry. They change only on a clock edge where the flag-load strobe is high. The decoder raises that strobe for a compare, which is a subtract whose result is discarded. Ordinary add, subtract and logic operations write their result and leave the flags untouched. The flags feed the conditional jump and call logic elsewhere in the core.

Top module: `alu8_shf`

## Requirements
- R1: Function code 0 gives the bitwise inverse of operand A, code 1 gives A AND B, code 2 gives A XOR B and code 3 gives A OR B.
- R2: Function code 5 gives A plus B modulo 256, and function code 6 gives A minus B modulo 256.
- R3: Function codes 4 and 7 pass operand A to the shift stage unchanged.
- R4: When `imm_sel` is 1, `imm` takes the place of `op_b` in every function. When `imm_sel` is 0, `imm` has no effect.
- R5: Shift code 0 shifts the function output left and fills bit 0 with 0. Code 5 shifts left and fills bit 0 with 1. Code 2 shifts right and fills bit 7 with 0. Code 6 shifts right and fills bit 7 with 1.
- R6: Shift code 1 rotates the function output left, moving bit 7 into bit 0. Code 3 rotates right, moving bit 0 into bit 7.
- R7: Shift codes 4 and 7 put the function output on `result` unchanged.
- R8: The flags take new values only on a rising clock edge where `flag_ld` is 1. At every other edge they keep their values.
- R9: On a load edge, `zero_flag` becomes 1 exactly when `result` is 0x00. `carry_flag` becomes the carry out of A+B for code 5, becomes the borrow (A < B unsigned) for code 6, and becomes 0 for every other code.
- R10: `rst` clears both flags at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rst | input | 1 | Asynchronous active-high reset of the flags |
| op_a | input | 8 | Operand A from the register file |
| op_b | input | 8 | Operand B from the register file |
| imm | input | 8 | Immediate operand |
| imm_sel | input | 1 | Selects `imm` in place of `op_b` |
| func_code | input | 3 | Function select |
| shift_code | input | 3 | Shift and rotate select |
| flag_ld | input | 1 | Flag-load strobe |
| result | output | 8 | Function output after the shift stage |
| zero_flag | output | 1 | Registered zero flag |
| carry_flag | output | 1 | Registered carry or borrow flag |

## Verification
A flag load can occur in the same cycle as a non-trivial shift. In that case the zero flag must follow the shifted result, while the carry flag must follow the function stage. The bench provokes this with a subtract whose difference is 0x80 and a left shift with 0 fill, so the result is 0x00. It expects zero set and carry clear. It also loads flags on an add whose sum wraps to zero, which sets both flags in the same edge. A reference model built from integer arithmetic is compared against `result` and both flags on every clock.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    FN_NOT  = 3'd0,
    FN_AND  = 3'd1,
    FN_XOR  = 3'd2,
    FN_OR   = 3'd3,
    FN_PASS = 3'd4,
    FN_ADD  = 3'd5,
    FN_SUB  = 3'd6,
    FN_RSV  = 3'd7
  } alu_fn_e;

  typedef enum logic [2:0] {
    SH_SL0  = 3'd0,
    SH_ROL  = 3'd1,
    SH_SR0  = 3'd2,
    SH_ROR  = 3'd3,
    SH_NONE = 3'd4,
    SH_SL1  = 3'd5,
    SH_SR1  = 3'd6,
    SH_RSV  = 3'd7
  } alu_sh_e;
endpackage

// File: rtl/alu8_fn_stage.sv
module alu8_fn_stage
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         carry
);
  localparam int XW = W + 1;

  // bit W carries the adder carry-out or the subtract borrow
  function automatic logic [XW-1:0] fn_eval(input logic [W-1:0] x,
                                            input logic [W-1:0] z,
                                            input alu_fn_e f);
    logic [XW-1:0] r;
    case (f)
      FN_NOT:  r = {1'b0, ~x};
      FN_AND:  r = {1'b0, x & z};
      FN_XOR:  r = {1'b0, x ^ z};
      FN_OR:   r = {1'b0, x | z};
      FN_ADD:  r = {1'b0, x} + {1'b0, z};
      FN_SUB:  r = {1'b0, x} - {1'b0, z};
      default: r = {1'b0, x};
    endcase
    return r;
  endfunction

  logic [XW-1:0] wide;
  always_comb wide = fn_eval(a, b, fn);
  assign y     = wide[W-1:0];
  assign carry = wide[W];
endmodule

// File: rtl/alu8_shift_stage.sv
module alu8_shift_stage
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  alu_sh_e      sh,
  output logic [W-1:0] dout
);
  localparam int MSB = W - 1;

  function automatic logic [W-1:0] shift_eval(input logic [W-1:0] v,
                                              input alu_sh_e s);
    logic [W-1:0] r;
    case (s)
      SH_SL0:  r = {v[MSB-1:0], 1'b0};
      SH_SL1:  r = {v[MSB-1:0], 1'b1};
      SH_SR0:  r = {1'b0, v[MSB:1]};
      SH_SR1:  r = {1'b1, v[MSB:1]};
      SH_ROL:  r = {v[MSB-1:0], v[MSB]};
      SH_ROR:  r = {v[0], v[MSB:1]};
      default: r = v;
    endcase
    return r;
  endfunction

  always_comb dout = shift_eval(din, sh);
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic zero_in,
  input  logic carry_in,
  output logic zero_q,
  output logic carry_q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      zero_q  <= 1'b0;
      carry_q <= 1'b0;
    end else if (ld) begin
      zero_q  <= zero_in;
      carry_q <= carry_in;
    end
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable({zero_q, carry_q})); // R8

  AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld |=> {zero_q, carry_q} == $past({zero_in, carry_in})); // R9
endmodule

// File: rtl/alu8_shf.sv
module alu8_shf
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] imm,
  input  logic         imm_sel,
  input  logic [2:0]   func_code,
  input  logic [2:0]   shift_code,
  input  logic         flag_ld,
  output logic [W-1:0] result,
  output logic         zero_flag,
  output logic         carry_flag
);
  localparam logic [W-1:0] ZERO_W = '0;

  alu_fn_e      fn;
  alu_sh_e      sh;
  logic [W-1:0] b_eff;
  logic [W-1:0] fn_y;
  logic         fn_carry;
  logic         zero_next;

  assign fn    = alu_fn_e'(func_code);
  assign sh    = alu_sh_e'(shift_code);
  assign b_eff = imm_sel ? imm : op_b;

  alu8_fn_stage #(.W(W)) u_fn (
    .a(op_a), .b(b_eff), .fn(fn), .y(fn_y), .carry(fn_carry)
  );

  alu8_shift_stage #(.W(W)) u_sh (
    .din(fn_y), .sh(sh), .dout(result)
  );

  assign zero_next = (result == ZERO_W);

  alu8_flag_reg u_flags (
    .clk(clk), .rst(rst), .ld(flag_ld),
    .zero_in(zero_next), .carry_in(fn_carry),
    .zero_q(zero_flag), .carry_q(carry_flag)
  );

  // named events for the checks below
  logic ev_rotate, ev_sub, ev_pass, ev_noshift, ev_imm_add;
  assign ev_rotate  = (sh == SH_ROL) || (sh == SH_ROR);
  assign ev_sub     = (fn == FN_SUB);
  assign ev_pass    = (fn == FN_PASS) || (fn == FN_RSV);
  assign ev_noshift = (sh == SH_NONE) || (sh == SH_RSV);
  assign ev_imm_add = imm_sel && (fn == FN_ADD);

  AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
    ev_rotate |-> $countones(result) == $countones(fn_y)); // R6

  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
    ev_sub |-> fn_carry == (op_a < b_eff)); // R9

  AST_PASS_A: assert property (@(posedge clk) disable iff (rst)
    (ev_pass && ev_noshift) |-> result == op_a); // R3

  AST_IMM_ADD: assert property (@(posedge clk) disable iff (rst)
    (ev_imm_add && ev_noshift) |-> result == W'(op_a + imm)); // R4
endmodule

// File: tb/alu8_shf_bench.sv
`timescale 1ns/1ps
module alu8_shf_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] op_a = '0, op_b = '0, imm = '0;
  logic       imm_sel = 1'b0;
  logic [2:0] func_code = 3'd4, shift_code = 3'd4;
  logic       flag_ld = 1'b0;
  logic [7:0] result;
  logic       zero_flag, carry_flag;

  int checks = 0;
  int errors = 0;
  int m_z = 0, m_c = 0;

  always #2.5 clk = ~clk;

  alu8_shf u_alu8_shf (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .imm(imm),
    .imm_sel(imm_sel), .func_code(func_code), .shift_code(shift_code),
    .flag_ld(flag_ld), .result(result), .zero_flag(zero_flag),
    .carry_flag(carry_flag)
  );

  // reference: integer arithmetic, function part; returns value + 256*carry
  function automatic int ref_fn(int a, int b, int f);
    case (f)
      0: return 255 - a;
      1: return a & b;
      2: return a ^ b;
      3: return a | b;
      5: return a + b;
      6: return (a < b) ? (a - b + 256 + 256) : (a - b);
      default: return a;
    endcase
  endfunction

  function automatic int ref_sh(int v, int s);
    case (s)
      0: return (v * 2) % 256;
      5: return (v * 2) % 256 + 1;
      2: return v / 2;
      6: return v / 2 + 128;
      1: return (v * 2) % 256 + v / 128;
      3: return v / 2 + (v % 2) * 128;
      default: return v;
    endcase
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // called at a negedge: drive, check result, model the edge, check flags
  task automatic step(int a, int b, int im, bit isel, int f, int s, bit ld,
                      string tag);
    int bb, fr, r, c;
    op_a = 8'(a); op_b = 8'(b); imm = 8'(im); imm_sel = isel;
    func_code = 3'(f); shift_code = 3'(s); flag_ld = ld;
    bb = isel ? im : b;
    fr = ref_fn(a, bb, f);
    c  = (f == 5 || f == 6) ? fr / 256 : 0;
    r  = ref_sh(fr % 256, s);
    #1;
    check(tag, "result", int'(result), r);
    @(posedge clk);
    if (ld) begin
      m_z = (r == 0) ? 1 : 0;
      m_c = c;
    end
    @(negedge clk);
    check(ld ? tag : "R8", "zero", int'(zero_flag), m_z);
    check(ld ? tag : "R8", "carry", int'(carry_flag), m_c);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R10", "zero after reset", int'(zero_flag), 0);
    check("R10", "carry after reset", int'(carry_flag), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 logic functions
    for (int f = 0; f < 4; f++) step(8'hA5, 8'h3C, 0, 0, f, 4, 0, "R1");
    step(8'h00, 8'hFF, 0, 0, 0, 4, 0, "R1");
    // R2 add / subtract without strobe: flags stay
    step(8'hF0, 8'h20, 0, 0, 5, 4, 0, "R2");
    step(8'h10, 8'h20, 0, 0, 6, 4, 0, "R2");
    // R3 pass codes with R7 no-shift codes
    step(8'h5A, 8'hFF, 8'h11, 1, 4, 4, 0, "R3");
    step(8'hC3, 8'h00, 0, 0, 7, 7, 0, "R7");
    // R4 immediate replaces B; ignored when not selected
    step(8'h40, 8'h00, 8'h11, 1, 5, 4, 0, "R4");
    step(8'h40, 8'h02, 8'hEE, 0, 5, 4, 0, "R4");
    step(8'hF0, 8'h00, 8'h0F, 1, 1, 4, 0, "R4");
    // R5 fill shifts, R6 rotates on a passed value
    step(8'h81, 0, 0, 0, 4, 0, 0, "R5");
    step(8'h81, 0, 0, 0, 4, 5, 0, "R5");
    step(8'h81, 0, 0, 0, 4, 2, 0, "R5");
    step(8'h81, 0, 0, 0, 4, 6, 0, "R5");
    step(8'h81, 0, 0, 0, 4, 1, 0, "R6");
    step(8'h81, 0, 0, 0, 4, 3, 0, "R6");
    step(8'h02, 8'h01, 0, 0, 2, 3, 0, "R6");
    // R9 compare loads
    step(8'h05, 8'h09, 0, 0, 6, 4, 1, "R9");
    step(8'h09, 8'h09, 0, 0, 6, 4, 1, "R9");
    step(8'hFF, 8'h01, 0, 0, 5, 4, 1, "R9");
    step(8'h00, 8'h00, 0, 0, 1, 4, 1, "R9");
    step(8'hFF, 8'hFF, 0, 0, 5, 4, 1, "R9");
    step(8'h00, 8'h00, 0, 0, 1, 4, 0, "R8");
    // coincidence: load with shift, zero from shifted result
    step(8'h80, 8'h00, 0, 0, 6, 0, 1, "R9");
    step(8'h80, 8'h01, 8'h00, 1, 6, 2, 1, "R9");
    // mixed patterns
    for (int i = 0; i < 200; i++)
      step(int'($urandom % 256), int'($urandom % 256), int'($urandom % 256),
           1'($urandom % 2), int'($urandom % 8), int'($urandom % 8),
           1'($urandom % 2), "R2");
    // R10 asynchronous reset mid-cycle
    step(8'h01, 8'h02, 0, 0, 6, 4, 1, "R9");
    #1 rst = 1'b1;
    #0.5;
    check("R10", "zero async", int'(zero_flag), 0);
    check("R10", "carry async", int'(carry_flag), 0);
    m_z = 0; m_c = 0;
    @(negedge clk);
    rst = 1'b0;
    step(8'h33, 8'h44, 0, 0, 3, 4, 0, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule